// File: doc/BRIEF.md
# Edge-Qualified Interrupt and Trap Capture

This block turns four external interrupt request lines and one trap line into clean, one-shot pending flags for the processor core logic. Each line is active-high and fires on a low-to-high transition. Every line is sampled on the falling edge of the internal clock and then passes through a resynchronizing chain. A qualifier then accepts a rising edge only if the line stays high for at least two cycles. It also requires that the line has been low for at least two cycles before it re-arms.

The trap line is a bidirectional tri-state pad. After reset the block only listens to it. When a debug-control enable is set, the block drives the pad with a debug-supplied value. In that mode the driven value never counts as an incoming trap. A qualified trap event is broadcast to two core-facing pending flags, and each core clears its own flag.

Each pending flag stays set until its matching acknowledge input is sampled high on a rising clock edge. Downstream logic does arbitration and vectoring.

Top module: `irq_edge_capture`

## Requirements
- R1: Each of the four interrupt inputs and the trap pad (while it is an input) produces a pending event on a low-to-high transition of an active-high level.
- R2: Inputs are captured on the falling clock edge and resynchronized. If a line is driven high just after a rising edge and kept high, its pending flag is still low after three more rising edges and is set after the fourth.
- R3: A line that is high for only one cycle produces no pending event.
- R4: After an accepted assertion, a new rising edge is accepted only if the line was low for at least two cycles before it. A one-cycle low gap is not enough.
- R5: A line that rises and then stays high produces exactly one pending event, even if its flag is acknowledged while the line is still high.
- R6: A pending flag remains set until its acknowledge input is high at a rising edge, and it is clear after that edge.
- R7: If a new qualified event and the acknowledge of the same flag land on the same rising edge, the flag stays set.
- R8: After reset the trap pad is not driven. While the debug enable is high, the pad carries the debug output value.
- R9: A trap event sets both core trap pending flags on the same edge, and each core's acknowledge clears only that core's flag.
- R10: While the debug enable drives the trap pad, the driven value never creates a trap pending event.
- R11: After reset all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock; inputs are captured on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 4 | External interrupt request lines, active-high |
| irq_ack | input | 4 | Per-line pending clear, sampled on the rising edge |
| irq_pend | output | 4 | Per-line interrupt pending flags |
| trap_pad | inout | 1 | Bidirectional tri-state trap line |
| dbg_trap_oe | input | 1 | Debug enable that turns the trap pad into a driven output |
| dbg_trap_out | input | 1 | Value driven on the trap pad while the debug enable is high |
| trap_ack | input | 2 | Per-core trap pending clear |
| trap_pend | output | 2 | Per-core trap pending flags |

## Verification
The embedded assertions check the following on every cycle:
- A qualifier event never repeats on consecutive cycles.
- A qualifier event always follows a high sample.
- The pending flags follow their set, clear and hold rules.
- A trap rise is seen by both cores together.
- A driven pad carries the debug value.
- No trap event appears while the pad has been driven for several cycles.

Only the directed scenarios can show the cycle-exact latency from pin to flag and the rejection of one-cycle pulses and one-cycle low gaps. They also show the single event for a held line and the same-edge collision between acknowledge and a new event.

// File: rtl/irq_cap_pkg.sv
`timescale 1ns/1ps
// Shared types for the interrupt/trap capture block.
package irq_cap_pkg;
    // Qualifier states: waiting for enough low time, counting high time, fired.
    typedef enum logic [1:0] {
        QS_LOW  = 2'd0,
        QS_HIGH = 2'd1,
        QS_DONE = 2'd2
    } qual_state_e;
endpackage

// File: rtl/edge_sync.sv
`timescale 1ns/1ps
// edge_sync: captures WIDTH asynchronous lines on the falling clock edge,
// then resynchronizes them through STAGES-1 rising-edge flops.
// Assumes STAGES >= 2 and a synchronous active-low reset.
module edge_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int RISE_N = STAGES - 1;

    logic [WIDTH-1:0] fall_q;
    logic [WIDTH-1:0] rise_q [RISE_N];

    // Falling-edge capture of the raw lines.
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= d;
    end

    // Rising-edge resynchronizer stages.
    for (genvar g = 0; g < RISE_N; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) rise_q[g] <= '0;
                else        rise_q[g] <= fall_q;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) rise_q[g] <= '0;
                else        rise_q[g] <= rise_q[g-1];
            end
        end
    end

    assign q = rise_q[RISE_N-1];
endmodule

// File: rtl/pulse_qualifier.sv
`timescale 1ns/1ps
// pulse_qualifier: turns one synchronized level into a one-cycle event.
// An event fires once the line has been low MIN_LOW samples, then high
// MIN_HIGH samples; it re-arms only after MIN_LOW further low samples.
// Assumes lvl is already synchronous to clk.
module pulse_qualifier
    import irq_cap_pkg::*;
#(
    parameter int MIN_HIGH = 2,
    parameter int MIN_LOW  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic evt
);
    localparam int CNT_MAX = (MIN_HIGH > MIN_LOW) ? MIN_HIGH : MIN_LOW;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] HI_N  = CW'(MIN_HIGH);
    localparam logic [CW-1:0] LO_N  = CW'(MIN_LOW);
    localparam logic [CW-1:0] SAT_N = CW'(CNT_MAX);
    localparam logic [CW-1:0] ONE   = CW'(1);

    qual_state_e st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          fire;

    // Next-state logic for the high/low width qualification.
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        fire  = 1'b0;
        case (st_q)
            QS_LOW: begin
                if (lvl) begin
                    if (cnt_q >= LO_N) begin
                        cnt_n = ONE;
                        if (HI_N <= ONE) begin
                            fire = 1'b1;
                            st_n = QS_DONE;
                        end else begin
                            st_n = QS_HIGH;
                        end
                    end else begin
                        cnt_n = '0;
                    end
                end else if (cnt_q < SAT_N) begin
                    cnt_n = cnt_q + ONE;
                end
            end
            QS_HIGH: begin
                if (lvl) begin
                    if (cnt_q + ONE >= HI_N) begin
                        fire = 1'b1;
                        st_n = QS_DONE;
                    end else begin
                        cnt_n = cnt_q + ONE;
                    end
                end else begin
                    st_n  = QS_LOW;
                    cnt_n = ONE;
                end
            end
            QS_DONE: begin
                if (!lvl) begin
                    st_n  = QS_LOW;
                    cnt_n = ONE;
                end
            end
            default: begin
                st_n  = QS_LOW;
                cnt_n = '0;
            end
        endcase
    end

    // State, counter and registered event pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= QS_LOW;
            cnt_q <= '0;
            evt   <= 1'b0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            evt   <= fire;
        end
    end

    // R5
    evt_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    // R3
    evt_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(lvl));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT_N);
endmodule

// File: rtl/pend_bank.sv
`timescale 1ns/1ps
// pend_bank: WIDTH sticky pending flags; set wins over clear on the same edge.
// Assumes set and ack are synchronous to clk.
module pend_bank #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] ack,
    output logic [WIDTH-1:0] pend
);
    // Sticky flag update: hold, clear on ack, set on event.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~ack) | set;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_chk
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[b] |=> pend[b]);
        // R6
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[b] && !set[b]) |=> !pend[b]);
        // R6
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[b] && !ack[b]) |=> pend[b]);
    end
endmodule

// File: rtl/irq_edge_capture.sv
`timescale 1ns/1ps
// irq_edge_capture: captures N_INT interrupt lines and a bidirectional trap
// pad, qualifies rising edges by minimum high/low widths, and keeps sticky
// pending flags (one per interrupt, one per core for the trap).
// Assumes the debug enable and value are synchronous to clk.
module irq_edge_capture #(
    parameter int N_INT       = 4,
    parameter int N_CORE      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_HIGH    = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_INT-1:0]  irq_in,
    input  logic [N_INT-1:0]  irq_ack,
    output logic [N_INT-1:0]  irq_pend,
    inout  wire               trap_pad,
    input  logic              dbg_trap_oe,
    input  logic              dbg_trap_out,
    input  logic [N_CORE-1:0] trap_ack,
    output logic [N_CORE-1:0] trap_pend
);
    localparam int N_LINE   = N_INT + 1;
    localparam int TRAP_IDX = N_INT;

    logic              trap_in;
    logic [N_LINE-1:0] raw_lines;
    logic [N_LINE-1:0] sync_lines;
    logic [N_LINE-1:0] line_evt;
    logic              trap_evt;

    // Pad driver: driven only under debug control, otherwise released.
    assign trap_pad = dbg_trap_oe ? dbg_trap_out : 1'bz;

    // Own driven value is masked so it is never seen as an incoming trap.
    assign trap_in   = trap_pad & ~dbg_trap_oe;
    assign raw_lines = {trap_in, irq_in};

    edge_sync #(.WIDTH(N_LINE), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    for (genvar i = 0; i < N_LINE; i++) begin : g_qual
        pulse_qualifier #(.MIN_HIGH(MIN_HIGH), .MIN_LOW(MIN_LOW)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (sync_lines[i]),
            .evt   (line_evt[i])
        );
    end

    assign trap_evt = line_evt[TRAP_IDX];

    pend_bank #(.WIDTH(N_INT)) u_irq_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (line_evt[N_INT-1:0]),
        .ack   (irq_ack),
        .pend  (irq_pend)
    );

    pend_bank #(.WIDTH(N_CORE)) u_trap_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   ({N_CORE{trap_evt}}),
        .ack   (trap_ack),
        .pend  (trap_pend)
    );

    for (genvar k = 0; k < N_CORE; k++) begin : g_fan_chk
        // R9
        trap_fanout_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(trap_pend[k]) |-> (&trap_pend));
    end

    // R8
    pad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap_oe |-> (trap_pad == dbg_trap_out));

    // R10
    trap_oe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_trap_oe && $past(dbg_trap_oe) && $past(dbg_trap_oe, 2)
         && $past(dbg_trap_oe, 3)) |-> !trap_evt);
endmodule

// File: tb/tb_irq_edge_capture.sv
`timescale 1ns/1ps
module tb_irq_edge_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] irq_in = '0;
    logic [3:0] irq_ack = '0;
    logic [3:0] irq_pend;
    wire        trap_pad;
    logic       dbg_trap_oe = 1'b0;
    logic       dbg_trap_out = 1'b0;
    logic [1:0] trap_ack = '0;
    logic [1:0] trap_pend;
    logic       tb_pad_en = 1'b1;
    logic       tb_pad_val = 1'b0;
    int         checks = 0;
    int         errors = 0;
    bit         reported = 1'b0;

    always #5 clk = ~clk;

    assign trap_pad = tb_pad_en ? tb_pad_val : 1'bz;

    irq_edge_capture dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .irq_ack      (irq_ack),
        .irq_pend     (irq_pend),
        .trap_pad     (trap_pad),
        .dbg_trap_oe  (dbg_trap_oe),
        .dbg_trap_out (dbg_trap_out),
        .trap_ack     (trap_ack),
        .trap_pend    (trap_pend)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic ack_irq(input int i);
        irq_ack[i] = 1'b1;
        step(1);
        irq_ack[i] = 1'b0;
    endtask

    task automatic t_reset();
        check(irq_pend == 4'h0, "R11 irq_pend", irq_pend, 0);
        check(trap_pend == 2'b00, "R11 trap_pend", trap_pend, 0);
    endtask

    task automatic t_latency();
        for (int i = 0; i < 4; i++) begin
            irq_in[i] = 1'b1;
            step(3);
            check(irq_pend[i] == 1'b0, "R2 early", irq_pend, 0);
            step(1);
            check(irq_pend == (4'h1 << i), "R1 R2 set", irq_pend, 4'h1 << i);
            irq_in[i] = 1'b0;
            step(1);
            ack_irq(i);
            check(irq_pend == 4'h0, "R6 cleared", irq_pend, 0);
            step(3);
        end
    endtask

    task automatic t_short_pulse();
        irq_in[1] = 1'b1;
        step(1);
        irq_in[1] = 1'b0;
        step(6);
        check(irq_pend[1] == 1'b0, "R3 one-cycle pulse", irq_pend, 0);
    endtask

    task automatic t_hold();
        irq_in[2] = 1'b1;
        step(10);
        check(irq_pend[2] == 1'b1, "R5 first event", irq_pend, 4'h4);
        ack_irq(2);
        step(12);
        check(irq_pend[2] == 1'b0, "R5 no second event", irq_pend, 0);
        irq_in[2] = 1'b0;
        step(4);
    endtask

    task automatic t_rearm();
        irq_in[3] = 1'b1;
        step(5);
        ack_irq(3);
        irq_in[3] = 1'b0;
        step(1);
        irq_in[3] = 1'b1;
        step(6);
        check(irq_pend[3] == 1'b0, "R4 one-cycle gap", irq_pend, 0);
        irq_in[3] = 1'b0;
        step(2);
        irq_in[3] = 1'b1;
        step(6);
        check(irq_pend[3] == 1'b1, "R4 two-cycle gap", irq_pend, 4'h8);
        irq_in[3] = 1'b0;
        ack_irq(3);
        step(3);
    endtask

    task automatic t_collide();
        irq_in[0] = 1'b1;
        step(5);
        irq_in[0] = 1'b0;
        step(4);
        check(irq_pend[0] == 1'b1, "R6 held without ack", irq_pend, 1);
        irq_in[0] = 1'b1;
        step(3);
        irq_ack[0] = 1'b1;
        step(1);
        irq_ack[0] = 1'b0;
        check(irq_pend[0] == 1'b1, "R7 ack vs event", irq_pend, 1);
        step(1);
        check(irq_pend[0] == 1'b1, "R7 stays set", irq_pend, 1);
        irq_in[0] = 1'b0;
        ack_irq(0);
        check(irq_pend[0] == 1'b0, "R6 clear after collide", irq_pend, 0);
        step(3);
    endtask

    task automatic t_trap_cores();
        tb_pad_val = 1'b1;
        step(3);
        check(trap_pend == 2'b00, "R2 trap early", trap_pend, 0);
        step(1);
        check(trap_pend == 2'b11, "R1 R9 trap both cores", trap_pend, 3);
        tb_pad_val = 1'b0;
        trap_ack = 2'b01;
        step(1);
        trap_ack = 2'b00;
        check(trap_pend == 2'b10, "R9 core0 ack only", trap_pend, 2);
        trap_ack = 2'b10;
        step(1);
        trap_ack = 2'b00;
        check(trap_pend == 2'b00, "R9 core1 ack", trap_pend, 0);
        step(3);
    endtask

    task automatic t_trap_output();
        tb_pad_en = 1'b0;
        dbg_trap_oe = 1'b1;
        dbg_trap_out = 1'b1;
        step(1);
        check(trap_pad == 1'b1, "R8 pad driven high", trap_pad, 1);
        dbg_trap_out = 1'b0;
        step(1);
        check(trap_pad == 1'b0, "R8 pad driven low", trap_pad, 0);
        for (int r = 0; r < 2; r++) begin
            dbg_trap_out = 1'b1;
            step(4);
            dbg_trap_out = 1'b0;
            step(4);
        end
        dbg_trap_oe = 1'b0;
        tb_pad_val = 1'b0;
        tb_pad_en = 1'b1;
        step(6);
        check(trap_pend == 2'b00, "R10 no self trap", trap_pend, 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
        $finish;
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        step(4);
        t_reset();
        t_latency();
        t_short_pulse();
        t_hold();
        t_rearm();
        t_collide();
        t_trap_cores();
        t_trap_output();
        report();
        $finish;
    end
endmodule